// File: doc/BRIEF.md
# Firmware Boot and Mailbox Sequencer

This block starts firmware that has already been copied into an embedded engine's memories, then collects the engine's two-word exit status. A request carries three things: the firmware entry address, and two optional argument words, each with its own valid flag. On a request, the sequencer acts as master on a simple register bus toward the engine. It first sets the engine's external memory interface to physical, coherent system memory accesses. It then writes the boot vector and any argument words flagged valid. It issues the start command and polls until the engine reports that it has halted.

The engine's control register can expose an alias-enable status bit. When that bit is set, the start command goes to an alias copy of the control register instead of the normal one. When the engine halts, both mailbox registers are read and presented as the result. If the halt does not arrive within a time window, the result is flagged as an error. The window is fixed by a clock-frequency parameter and a millisecond parameter. The register bus has single-cycle writes. A read presents its data on `bus_rdata` in the cycle after `bus_rd`.

Top module: `fwboot_seq`

## Requirements
- R1: After reset, `busy` and `res_valid` are 0 and neither `bus_wr` nor `bus_rd` is asserted until a request arrives.
- R2: An accepted request first writes 0x00000005 to address 0 (interface target field bits [1:0] = 1 for coherent system memory, memory-type bit 2 = 1 for physical). It then writes the entry address to address 1 (boot vector). Writes and reads are never issued in the same cycle.
- R3: Argument 0 is written to address 2 only when `req_arg0_ok` is 1. Argument 1 is written to address 3 only when `req_arg1_ok` is 1. The two decisions are independent of each other.
- R4: Every mailbox write of a request comes before that request's start command.
- R5: Before starting, the sequencer reads the control register at address 4. If bit 6 (alias enable) of that word is 1, it writes 0x00000002 (start, bit 1) to address 5. Otherwise it writes 0x00000002 to address 4.
- R6: After the start command, address 4 is read repeatedly until bit 4 (halted) is 1. Address 2 and then address 3 are then read. Their values appear on `res_word0` and `res_word1` with `res_valid` = 1 and `res_err` = 0.
- R7: If halted is not seen within CLK_KHZ*TIMEOUT_MS cycles of polling, the sequencer finishes with `res_valid` = 1, `res_err` = 1 and both result words 0.
- R8: A result, together with its valid and error flags, holds unchanged until the next request is accepted. That acceptance clears `res_valid`.
- R9: `req_valid` while `busy` is 1 is ignored. It causes no additional bus writes, and the running sequence completes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pulse, taken only when idle |
| req_entry | input | 32 | Firmware entry address |
| req_arg0 | input | 32 | Argument for mailbox 0 |
| req_arg0_ok | input | 1 | Argument 0 is to be written |
| req_arg1 | input | 32 | Argument for mailbox 1 |
| req_arg1_ok | input | 1 | Argument 1 is to be written |
| busy | output | 1 | Sequence in progress |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | 3 | Register word address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after bus_rd |
| res_valid | output | 1 | Result available |
| res_err | output | 1 | Halt timeout occurred |
| res_word0 | output | 32 | Mailbox 0 at halt |
| res_word1 | output | 32 | Mailbox 1 at halt |

## Verification
Two functions can meet in one stretch of cycles: the acceptance logic for a new request, and a boot sequence already running. The bench pulses `req_valid` with a different entry address while a long halt delay keeps the sequencer polling. A scoreboard queue holds only the first request's expected writes. Any write produced by the stray pulse arrives with an empty queue or a mismatching entry and is reported. The result of the running request must still match the engine model's mailbox values.

// File: rtl/fwboot_pkg.sv
package fwboot_pkg;
    localparam int DW = 32;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_XFER   = 3'd0;
    localparam logic [AW-1:0] A_BVEC   = 3'd1;
    localparam logic [AW-1:0] A_MBOX0  = 3'd2;
    localparam logic [AW-1:0] A_MBOX1  = 3'd3;
    localparam logic [AW-1:0] A_CTL    = 3'd4;
    localparam logic [AW-1:0] A_CTLALT = 3'd5;

    localparam int BIT_START = 1;
    localparam int BIT_HALT  = 4;
    localparam int BIT_ALIAS = 6;

    localparam logic [1:0] TGT_COH_SYS = 2'd1;
    localparam logic       MEM_PHYS    = 1'b1;

    typedef enum logic [3:0] {
        S_IDLE, S_CFG, S_BVEC, S_MB0, S_MB1, S_RDCTL, S_START,
        S_POLL_RD, S_POLL_CHK, S_RD0, S_CAP0, S_CAP1
    } state_t;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_cmd_t;

    function automatic logic [DW-1:0] xfer_word();
        logic [DW-1:0] w;
        w = '0;
        w[1:0] = TGT_COH_SYS;
        w[2]   = MEM_PHYS;
        return w;
    endfunction

    function automatic bus_cmd_t wr_cmd(logic [AW-1:0] a, logic [DW-1:0] d);
        bus_cmd_t c;
        c.wr = 1'b1; c.rd = 1'b0; c.addr = a; c.data = d;
        return c;
    endfunction

    function automatic bus_cmd_t rd_cmd(logic [AW-1:0] a);
        bus_cmd_t c;
        c.wr = 1'b0; c.rd = 1'b1; c.addr = a; c.data = '0;
        return c;
    endfunction
endpackage

// File: rtl/fwboot_timer.sv
module fwboot_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run && cnt_q < CW'(LIMIT))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= CW'(LIMIT - 1));

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt_q == '0);
endmodule

// File: rtl/fwboot_result.sv
module fwboot_result
    import fwboot_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          cap0,
    input  logic          cap1,
    input  logic [DW-1:0] data,
    input  logic          done,
    input  logic          err,
    output logic          valid,
    output logic          error,
    output logic [DW-1:0] word0,
    output logic [DW-1:0] word1
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid <= 1'b0;
            error <= 1'b0;
            word0 <= '0;
            word1 <= '0;
        end else begin
            if (cap0) word0 <= data;
            if (cap1) word1 <= data;
            if (done) begin
                valid <= 1'b1;
                error <= err;
            end
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (valid && !clr) |=> (valid && $stable(word0) && $stable(word1) && $stable(error)));
    p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (valid && error) |-> (word0 == '0 && word1 == '0));
endmodule

// File: rtl/fwboot_seq.sv
module fwboot_seq
    import fwboot_pkg::*;
#(
    parameter int CLK_KHZ    = 100000,
    parameter int TIMEOUT_MS = 2000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [DW-1:0] req_entry,
    input  logic [DW-1:0] req_arg0,
    input  logic          req_arg0_ok,
    input  logic [DW-1:0] req_arg1,
    input  logic          req_arg1_ok,
    output logic          busy,
    output logic          bus_wr,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          res_valid,
    output logic          res_err,
    output logic [DW-1:0] res_word0,
    output logic [DW-1:0] res_word1
);
    localparam int LIMIT = CLK_KHZ * TIMEOUT_MS;

    state_t        st_q, st_d;
    logic [DW-1:0] entry_q, arg0_q, arg1_q;
    logic          ok0_q, ok1_q, started_q;
    bus_cmd_t      cmd;
    logic          accept, expired, cap0, cap1, done, err;
    logic [DW-1:0] start_word;

    assign accept = req_valid && (st_q == S_IDLE);
    assign busy   = (st_q != S_IDLE);

    always_comb begin
        start_word = '0;
        start_word[BIT_START] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            entry_q   <= '0;
            arg0_q    <= '0;
            arg1_q    <= '0;
            ok0_q     <= 1'b0;
            ok1_q     <= 1'b0;
            started_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                entry_q   <= req_entry;
                arg0_q    <= req_arg0;
                arg1_q    <= req_arg1;
                ok0_q     <= req_arg0_ok;
                ok1_q     <= req_arg1_ok;
                started_q <= 1'b0;
            end else if (st_q == S_START) begin
                started_q <= 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        cmd  = '0;
        cap0 = 1'b0;
        cap1 = 1'b0;
        done = 1'b0;
        err  = 1'b0;
        unique case (st_q)
            S_IDLE:  if (accept) st_d = S_CFG;
            S_CFG:   begin cmd = wr_cmd(A_XFER, xfer_word()); st_d = S_BVEC; end
            S_BVEC:  begin cmd = wr_cmd(A_BVEC, entry_q);     st_d = S_MB0;  end
            S_MB0:   begin if (ok0_q) cmd = wr_cmd(A_MBOX0, arg0_q); st_d = S_MB1; end
            S_MB1:   begin if (ok1_q) cmd = wr_cmd(A_MBOX1, arg1_q); st_d = S_RDCTL; end
            S_RDCTL: begin cmd = rd_cmd(A_CTL); st_d = S_START; end
            S_START: begin
                cmd  = wr_cmd(bus_rdata[BIT_ALIAS] ? A_CTLALT : A_CTL, start_word);
                st_d = S_POLL_RD;
            end
            S_POLL_RD: begin cmd = rd_cmd(A_CTL); st_d = S_POLL_CHK; end
            S_POLL_CHK: begin
                if (bus_rdata[BIT_HALT]) st_d = S_RD0;
                else if (expired) begin
                    done = 1'b1;
                    err  = 1'b1;
                    st_d = S_IDLE;
                end else st_d = S_POLL_RD;
            end
            S_RD0:  begin cmd = rd_cmd(A_MBOX0); st_d = S_CAP0; end
            S_CAP0: begin cap0 = 1'b1; cmd = rd_cmd(A_MBOX1); st_d = S_CAP1; end
            S_CAP1: begin cap1 = 1'b1; done = 1'b1; st_d = S_IDLE; end
            default: st_d = S_IDLE;
        endcase
    end

    assign bus_wr    = cmd.wr;
    assign bus_rd    = cmd.rd;
    assign bus_addr  = cmd.addr;
    assign bus_wdata = cmd.data;

    fwboot_timer #(.LIMIT(LIMIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (st_q == S_START),
        .run     (st_q == S_POLL_RD || st_q == S_POLL_CHK),
        .expired (expired)
    );

    fwboot_result u_result (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .cap0  (cap0),
        .cap1  (cap1),
        .data  (bus_rdata),
        .done  (done),
        .err   (err),
        .valid (res_valid),
        .error (res_err),
        .word0 (res_word0),
        .word1 (res_word1)
    );

    p_excl_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));
    p_mbox_before_start_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == A_MBOX0 || bus_addr == A_MBOX1)) |-> !started_q);
    p_busy_no_result_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !res_valid);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(bus_wr || bus_rd));
    p_err_flagged_r7: assert property (@(posedge clk) disable iff (rst)
        res_err |-> res_valid);
endmodule

// File: tb/fwboot_seq_test.sv
module fwboot_seq_test;
    import fwboot_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int KHZ = 1;
    localparam int MS  = 100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [DW-1:0] req_entry = '0, req_arg0 = '0, req_arg1 = '0;
    logic          req_arg0_ok = 1'b0, req_arg1_ok = 1'b0;
    logic          busy, bus_wr, bus_rd, res_valid, res_err;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata, res_word0, res_word1;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } wexp_t;
    wexp_t exp_q[$];

    logic [DW-1:0] eng_reg [0:7];
    logic          eng_alias = 1'b0;
    logic          eng_halted = 1'b0;
    logic          eng_armed = 1'b0;
    int            eng_cnt = 0;
    int            halt_delay = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwboot_seq #(.CLK_KHZ(KHZ), .TIMEOUT_MS(MS)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_entry(req_entry),
        .req_arg0(req_arg0), .req_arg0_ok(req_arg0_ok), .req_arg1(req_arg1),
        .req_arg1_ok(req_arg1_ok), .busy(busy), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .res_valid(res_valid), .res_err(res_err), .res_word0(res_word0),
        .res_word1(res_word1)
    );

    // Engine register model
    initial begin
        for (int i = 0; i < 8; i++) eng_reg[i] = 32'h1000_0000 + i;
        bus_rdata = '0;
    end

    always @(posedge clk) begin
        if (bus_rd) begin
            if (bus_addr == A_CTL)
                bus_rdata <= {25'd0, eng_alias, 1'b0, eng_halted, 4'd0};
            else
                bus_rdata <= eng_reg[bus_addr];
        end
        if (bus_wr) begin
            eng_reg[bus_addr] <= bus_wdata;
            if ((bus_addr == A_CTL || bus_addr == A_CTLALT) && bus_wdata[BIT_START]) begin
                eng_halted <= 1'b0;
                eng_armed  <= (halt_delay >= 0);
                eng_cnt    <= halt_delay;
            end
        end else if (eng_armed) begin
            if (eng_cnt == 0) begin
                eng_halted <= 1'b1;
                eng_armed  <= 1'b0;
                eng_reg[2] <= eng_reg[2] ^ 32'hA5A5_0000;
                eng_reg[3] <= eng_reg[3] + 1;
            end else eng_cnt <= eng_cnt - 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && bus_wr) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected write", {29'd0, bus_addr}, '0);
            end else begin
                wexp_t e;
                e = exp_q.pop_front();
                check(bus_addr == e.a, (e.a < 2) ? "R2 addr" : (e.a < 4) ? "R3 addr" : "R5 addr",
                      {29'd0, bus_addr}, {29'd0, e.a});
                check(bus_wdata == e.d, (e.a < 2) ? "R2 data" : (e.a < 4) ? "R3 data" : "R5 data",
                      bus_wdata, e.d);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic run_boot(input logic [DW-1:0] entry, input logic [DW-1:0] a0, input bit ok0,
                            input logic [DW-1:0] a1, input bit ok1, input bit alias_on,
                            input int delay, input bit inject);
        logic [DW-1:0] m0, m1, e0, e1;
        wexp_t w;
        bit timeout;
        timeout   = (delay < 0);
        eng_alias = alias_on;
        halt_delay = delay;
        m0 = ok0 ? a0 : eng_reg[2];
        m1 = ok1 ? a1 : eng_reg[3];
        e0 = timeout ? '0 : (m0 ^ 32'hA5A5_0000);
        e1 = timeout ? '0 : (m1 + 1);
        w.a = A_XFER; w.d = 32'h5;   exp_q.push_back(w);
        w.a = A_BVEC; w.d = entry;   exp_q.push_back(w);
        if (ok0) begin w.a = A_MBOX0; w.d = a0; exp_q.push_back(w); end
        if (ok1) begin w.a = A_MBOX1; w.d = a1; exp_q.push_back(w); end
        w.a = alias_on ? A_CTLALT : A_CTL; w.d = 32'h2; exp_q.push_back(w);
        @(negedge clk);
        req_entry = entry; req_arg0 = a0; req_arg0_ok = ok0;
        req_arg1 = a1; req_arg1_ok = ok1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R8 busy", {31'd0, busy}, 32'd1);
        check(res_valid == 1'b0, "R8 clear on accept", {31'd0, res_valid}, 32'd0);
        if (inject) begin
            repeat (4) @(negedge clk);
            req_entry = 32'hDEAD_0000; req_arg0_ok = 1'b1; req_valid = 1'b1;
            repeat (2) @(negedge clk);
            req_valid = 1'b0;
        end
        for (int i = 0; i < 2000 && !res_valid; i++) @(negedge clk);
        check(exp_q.size() == 0, "R4 all writes issued before end", exp_q.size(), 0);
        check(res_valid == 1'b1, timeout ? "R7 valid" : "R6 valid", {31'd0, res_valid}, 32'd1);
        check(res_err == timeout, timeout ? "R7 err" : "R6 err", {31'd0, res_err}, {31'd0, timeout});
        check(res_word0 == e0, timeout ? "R7 word0" : "R6 word0", res_word0, e0);
        check(res_word1 == e1, timeout ? "R7 word1" : "R6 word1", res_word1, e1);
        repeat (6) @(negedge clk);
        check(res_valid && res_word0 == e0 && res_word1 == e1 && res_err == timeout,
              "R8 hold", res_word0, e0);
        check(!busy && !bus_wr && !bus_rd, "R9 idle after done", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!busy && !res_valid && !bus_wr && !bus_rd, "R1 reset state",
                  {28'd0, busy, res_valid, bus_wr, bus_rd}, 32'd0);
        end
        run_boot(32'h0000_4000, 32'h1111_2222, 1, 32'h3333_4444, 1, 0, 5, 0);
        run_boot(32'h0000_8100, 32'hCAFE_0001, 1, 32'hBAD0_BAD0, 0, 1, 0, 0);
        run_boot(32'h0001_0000, 32'hFFFF_FFFF, 0, 32'h0000_0077, 1, 0, 20, 1);
        run_boot(32'h0000_0200, 32'h0, 0, 32'h0, 0, 1, 3, 0);
        run_boot(32'h0000_0300, 32'h5555_AAAA, 1, 32'h0F0F_0F0F, 1, 0, -1, 0);
        run_boot(32'h0000_0400, 32'h7777_0000, 1, 32'h0000_8888, 1, 1, 2, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule